// File: doc/BRIEF.md
# Power Mode Control Register

This block is a byte-wide special-function register for a small microcontroller core. It also holds the logic that moves the core into and out of its low-power modes. It answers bus writes and reads at one special-function address. It drives the idle and powerdown requests that go to the clock-gating logic. It drives a baud-doubling control to the serial port. It also drives a select line that steers the top bit of the serial control register to either the framing-error flag or the serial mode bit.

Hardware also updates three fields. An interrupt or a reset clears both mode bits. A rising power-good input sets a power-off flag, and reset does not clear that flag, so software can tell a cold start from a warm reset. Two general flags are plain storage. The reserved position always reads back as zero.

Bit positions (MSB to LSB): 7 baud double, 6 serial top-bit select, 5 reserved, 4 power-off flag, 3 general flag 1, 2 general flag 0, 1 powerdown, 0 idle.

Top module: `pwr_mode_reg`

## Requirements
- R1: After an asynchronous reset, bits 7, 6, 3, 2, 1 and 0 read as 0, and `idle_o`, `pdown_o`, `baud_x2_o` and `scon7_fe_sel_o` are all 0.
- R2: A write strobe with `sfr_addr_i` equal to `REG_ADDR` (default 0x87) loads the data byte at the next clock edge. A write at any other address changes no bit and no output.
- R3: While `sfr_rd_i` is high with `sfr_addr_i` equal to `REG_ADDR`, `sfr_rdata_o` shows the register in the bit layout given above, in the same cycle. At every other time `sfr_rdata_o` is 0.
- R4: Bit 5 always reads as 0, and writing 1 to it has no effect.
- R5: `pdown_o` equals bit 1. `idle_o` equals bit 0 AND NOT bit 1, so powerdown wins when both bits are set.
- R6: A cycle with `irq_i` high clears bits 1 and 0 at the next edge and leaves all other bits unchanged.
- R7: When `irq_i` is high in the same cycle as a register write that sets bit 1 or bit 0, both mode bits end up 0. The other fields of that write still load.
- R8: The power-off flag (bit 4) has no reset. It becomes 1 on the third clock edge after `power_good_i` rises from 0, because the input passes through a two-flop synchronizer. Reset leaves bit 4 at whatever value it holds.
- R9: Software can write bit 4 to 0 or 1. If the hardware set and a software write of 0 fall on the same edge, the flag ends up 1.
- R10: `baud_x2_o` follows bit 7. `scon7_fe_sel_o` follows bit 6, where 1 selects the framing-error flag and 0 selects the serial mode bit.
- R11: General flags 1 and 0 (bits 3 and 2) store and read back what was written, and they change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | ADDR_W | Special-function bus address |
| sfr_wr_i | input | 1 | Write strobe |
| sfr_rd_i | input | 1 | Read strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data; 0 when the register is not being read |
| irq_i | input | 1 | Interrupt taken; clears both mode bits |
| power_good_i | input | 1 | Supply-good level, asynchronous to the clock |
| idle_o | output | 1 | Idle mode request |
| pdown_o | output | 1 | Powerdown mode request |
| baud_x2_o | output | 1 | Baud-rate doubling to the serial port |
| scon7_fe_sel_o | output | 1 | Serial control top-bit steering (1 = framing error) |

## Verification
Two pairs of events can land on the same clock edge. The first is an interrupt and a software write that sets a mode bit. The second is the synchronized power-good rise and a software write that clears the power-off flag.

The bench makes each pair coincide on purpose. For the interrupt case, it raises `irq_i` in the very cycle of the write. For the power-good case, it counts the synchronizer edges so the write lands on the edge where the flag is set. It then reads the register back. The result passes only if hardware won the shared bit and the rest of the written byte still loaded.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int unsigned DATA_W = 8;

  // field positions are software-visible
  localparam int unsigned BIT_IDL = 0;
  localparam int unsigned BIT_PD  = 1;
  localparam int unsigned BIT_GF0 = 2;
  localparam int unsigned BIT_GF1 = 3;
  localparam int unsigned BIT_POF = 4;
  localparam int unsigned BIT_RSV = 5;
  localparam int unsigned BIT_SEL = 6;
  localparam int unsigned BIT_BDX = 7;

  typedef struct packed {
    logic bdx;
    logic sel;
    logic rsv;
    logic pof;
    logic gf1;
    logic gf0;
    logic pd;
    logic idl;
  } pmr_t;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h87)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic match;
  assign match    = (addr_i == REG_ADDR);
  assign wr_hit_o = wr_i & match;
  assign rd_hit_o = rd_i & match;
endmodule

// File: rtl/pwr_mode_pg_edge.sv
module pwr_mode_pg_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic pg_i,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_N - 1;

  // no reset: must see supply rise even across a reset
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i) sync_q[0] <= pg_i;

  for (genvar g = 1; g < SYNC_N; g++) begin : g_sync
    always_ff @(posedge clk_i) sync_q[g] <= sync_q[g-1];
  end

  always_ff @(posedge clk_i) prev_q <= sync_q[LAST];

  assign rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hit_i,
  input  pmr_t wdata_i,
  input  logic irq_i,
  input  logic pg_rise_i,
  output pmr_t q_o
);
  logic bdx_q, sel_q, gf1_q, gf0_q, pd_q, idl_q, pof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bdx_q <= 1'b0;
      sel_q <= 1'b0;
      gf1_q <= 1'b0;
      gf0_q <= 1'b0;
    end else if (wr_hit_i) begin
      bdx_q <= wdata_i.bdx;
      sel_q <= wdata_i.sel;
      gf1_q <= wdata_i.gf1;
      gf0_q <= wdata_i.gf0;
    end
  end

  // interrupt clear beats a software set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q  <= 1'b0;
      idl_q <= 1'b0;
    end else if (irq_i) begin
      pd_q  <= 1'b0;
      idl_q <= 1'b0;
    end else if (wr_hit_i) begin
      pd_q  <= wdata_i.pd;
      idl_q <= wdata_i.idl;
    end
  end

  // survives reset; hardware set beats software write
  always_ff @(posedge clk_i) begin
    if (pg_rise_i)     pof_q <= 1'b1;
    else if (wr_hit_i) pof_q <= wdata_i.pof;
  end

  always_comb begin
    q_o     = '0;
    q_o.bdx = bdx_q;
    q_o.sel = sel_q;
    q_o.pof = pof_q;
    q_o.gf1 = gf1_q;
    q_o.gf0 = gf0_q;
    q_o.pd  = pd_q;
    q_o.idl = idl_q;
  end
endmodule

// File: rtl/pwr_mode_outs.sv
module pwr_mode_outs
  import pwr_mode_pkg::*;
(
  input  pmr_t q_i,
  output logic idle_o,
  output logic pdown_o,
  output logic baud_x2_o,
  output logic fe_sel_o
);
  assign pdown_o   = q_i.pd;
  assign idle_o    = q_i.idl & ~q_i.pd;
  assign baud_x2_o = q_i.bdx;
  assign fe_sel_o  = q_i.sel;
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
  import pwr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h87),
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic              sfr_rd_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  input  logic              irq_i,
  input  logic              power_good_i,
  output logic              idle_o,
  output logic              pdown_o,
  output logic              baud_x2_o,
  output logic              scon7_fe_sel_o
);
  logic wr_hit, rd_hit, pg_rise;
  pmr_t q;

  pwr_mode_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr_i   (sfr_addr_i),
    .wr_i     (sfr_wr_i),
    .rd_i     (sfr_rd_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  pwr_mode_pg_edge #(.SYNC_N(SYNC_N)) u_pg (
    .clk_i  (clk_i),
    .pg_i   (power_good_i),
    .rise_o (pg_rise)
  );

  pwr_mode_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hit_i  (wr_hit),
    .wdata_i   (pmr_t'(sfr_wdata_i)),
    .irq_i     (irq_i),
    .pg_rise_i (pg_rise),
    .q_o       (q)
  );

  pwr_mode_outs u_outs (
    .q_i       (q),
    .idle_o    (idle_o),
    .pdown_o   (pdown_o),
    .baud_x2_o (baud_x2_o),
    .fe_sel_o  (scon7_fe_sel_o)
  );

  assign sfr_rdata_o = rd_hit ? 8'(q) : 8'h00;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h87)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] sfr_addr_i,
  input logic              sfr_wr_i,
  input logic              sfr_rd_i,
  input logic [7:0]        sfr_wdata_i,
  input logic [7:0]        sfr_rdata_o,
  input logic              irq_i,
  input logic              idle_o,
  input logic              pdown_o,
  input logic              baud_x2_o,
  input logic              scon7_fe_sel_o
);
  // R5
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idle_o && pdown_o));

  // R6
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> (!idle_o && !pdown_o));

  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && sfr_addr_i == REG_ADDR) |=>
      (baud_x2_o == $past(sfr_wdata_i[7]) && scon7_fe_sel_o == $past(sfr_wdata_i[6])));

  // R2
  wr_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && sfr_addr_i != REG_ADDR && !irq_i) |=>
      ($stable(baud_x2_o) && $stable(scon7_fe_sel_o) && $stable(idle_o) && $stable(pdown_o)));

  // R4
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_rd_i |-> !sfr_rdata_o[5]);

  // R3
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sfr_rd_i |-> (sfr_rdata_o == 8'h00));
endmodule

bind pwr_mode_reg pwr_mode_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/pwr_mode_reg_tb_top.sv
module pwr_mode_reg_tb_top;
  localparam logic [7:0] ADDR = 8'h87;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0, irq = 1'b0, pg = 1'b0;
  logic [7:0] rdata;
  logic idle, pdown, bx2, fesel;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwr_mode_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(addr), .sfr_wr_i(wr), .sfr_rd_i(rd),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .irq_i(irq), .power_good_i(pg),
    .idle_o(idle), .pdown_o(pdown), .baud_x2_o(bx2), .scon7_fe_sel_o(fesel)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] a, input logic [7:0] d, input logic with_irq);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; irq = with_irq;
    @(negedge clk);
    wr = 1'b0; irq = 1'b0;
    #1;
  endtask

  task automatic read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] outs();
    return {4'b0, bx2, fesel, pdown, idle};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 outputs", outs(), 8'h00);
    check("R3 rdata idle", rdata, 8'h00);
    read(ADDR, d);
    check("R1 reg", d & 8'hEF, 8'h00);
  endtask

  task automatic t_pof_hw();
    logic [7:0] d;
    @(negedge clk); pg = 1'b1;
    repeat (5) @(negedge clk);
    read(ADDR, d);
    check("R8 pof set", d, 8'h10);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    write(ADDR, 8'hFF, 1'b0);
    check("R5 pd wins", outs(), 8'h0E);
    read(ADDR, d);
    check("R4 rsv reads 0", d, 8'hDF);
    write(ADDR, 8'h01, 1'b0);
    check("R5 idle only", outs(), 8'h01);
    read(ADDR, d);
    check("R9 sw clear pof", d, 8'h01);
    write(ADDR, 8'h40, 1'b0);
    check("R10 sel only", outs(), 8'h04);
    write(ADDR, 8'h81, 1'b0);
    check("R10 bdx", outs(), 8'h09);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    write(8'h86, 8'h7E, 1'b0);
    check("R2 other addr outs", outs(), 8'h09);
    read(ADDR, d);
    check("R2 other addr reg", d, 8'h81);
    read(8'h86, d);
    check("R3 other addr read", d, 8'h00);
  endtask

  task automatic t_gflags();
    logic [7:0] d;
    write(ADDR, 8'h0C, 1'b0);
    check("R11 no outs", outs(), 8'h00);
    read(ADDR, d);
    check("R11 readback", d, 8'h0C);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    write(ADDR, 8'h8F, 1'b0);
    check("R6 pre", outs(), 8'h0A);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    #1 check("R6 outs", outs(), 8'h08);
    read(ADDR, d);
    check("R6 reg", d, 8'h8C);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    write(ADDR, 8'h43, 1'b1);
    check("R7 outs", outs(), 8'h04);
    read(ADDR, d);
    check("R7 reg", d, 8'h40);
  endtask

  task automatic t_pof_collide();
    logic [7:0] d;
    @(negedge clk); pg = 1'b0;
    repeat (5) @(negedge clk);
    pg = 1'b1;
    repeat (2) @(negedge clk);
    addr = ADDR; wdata = 8'h00; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    read(ADDR, d);
    check("R9 hw set wins", d, 8'h10);
  endtask

  task automatic t_reset_keeps_pof();
    logic [7:0] d;
    do_reset();
    read(ADDR, d);
    check("R8 pof kept 1", d, 8'h10);
    write(ADDR, 8'h00, 1'b0);
    do_reset();
    read(ADDR, d);
    check("R8 pof kept 0", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_pof_hw();
    t_write_read();
    t_other_addr();
    t_gflags();
    t_irq();
    t_collide();
    t_pof_collide();
    t_reset_keeps_pof();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule